// File: doc/BRIEF.md
# Stereo Sample Serial Output Port

This block takes one stereo sample pair at a time (a left and a right 20-bit two's-complement word) and shifts it out on a single data line. Each sample period is split into a left half and a right half of 32 bit slots each. Data goes out MSB first, left before right. Two static mode pins choose the role and the format. In master mode the block derives a bit clock, a frame clock and a 16-slot qualifier strobe from its master clock. In slave mode it follows a bit clock, a frame clock and a qualifier supplied from outside. In slave mode those external signals are synchronised into the master-clock domain, and their edges are detected there.

Sample pairs enter through a valid/ready port with a single holding entry. `smp_ready_o` is high only while that entry is empty. A pair is taken on a clock edge where both `smp_valid_i` and `smp_ready_o` are high. While ready is low, the source must hold the pair and keep valid asserted. The held pair moves into the shadow register that feeds the serializer only at the start of a left half. That is the frame-clock transition into the left level, or the slot-63 to slot-0 wrap in master mode. This makes the held entry free again. If no new pair has arrived by then, the previous pair is sent again.

Top module: `stereo_out_serializer`

## Requirements
- R1: `mode_i[0]`=1 selects master: the block drives `bclk_o`, `fclk_o` and `qual_o`. `mode_i[0]`=0 selects slave: those three outputs stay low and the `ext_*` inputs are used.
- R2: With `mode_i[1]`=0 the left channel is marked by frame clock high and right by low. With `mode_i[1]`=1 left is low and right is high. This applies to `fclk_o` in master mode and to `ext_fclk_i` in slave mode.
- R3: Each channel occupies 32 bit slots, numbered 0..31 from the frame-clock edge. The 20 sample bits go out MSB first, left half before right half. Every slot not holding a sample bit drives `sdata_o` low.
- R4: In slave mode with `mode_i[1]`=0 (justified), the MSB is in slot 0, launched by the frame-clock edge. In every other mode the MSB is in slot 1, so bit k of the word (k=19..0) is in slot 20-k.
- R5: In master mode `bclk_o` has a period of 4 master clocks (2 high, 2 low) when `rate_384_i`=0, and 6 master clocks (3 high, 3 low) when it is 1. `sdata_o` and `fclk_o` change only on the master-clock edge where `bclk_o` falls.
- R6: In master mode `qual_o` is high in slots 1..16 of each channel and low otherwise. It is a twice-per-sample strobe with equal high and low time, covering the upper 16 data bits. The lower 4 bits follow in slots 17..20.
- R7: In slave justified mode the slot advances on a falling edge of `ext_bclk_i` only while `ext_qual_i` is high, and saturates at 31. A frame-clock edge restarts at slot 0, and takes precedence over a bit-clock fall detected in the same cycle.
- R8: In slave I2S mode (`mode_i`=2'b10) `ext_qual_i` has no effect: the slot advances on every `ext_bclk_i` fall.
- R9: The input port holds one pair, with `smp_ready_o` equal to "holding entry empty". A held pair enters the shadow register only at the start of a left half. A pair accepted in mid-frame does not change the frame in progress. With no new pair, the last pair repeats.
- R10: After reset `smp_ready_o` is high, the shadow pair is zero and `sdata_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (256fs or 384fs) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | [0]=master select, [1]=I2S format / inverted frame polarity; static |
| rate_384_i | input | 1 | Master clock ratio: 0=256fs, 1=384fs; static |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Holding entry empty |
| smp_left_i | input | SAMPLE_W | Left sample, two's complement |
| smp_right_i | input | SAMPLE_W | Right sample, two's complement |
| ext_bclk_i | input | 1 | Slave bit clock |
| ext_fclk_i | input | 1 | Slave frame clock |
| ext_qual_i | input | 1 | Slave bit-advance qualifier (justified mode only) |
| bclk_o | output | 1 | Master bit clock |
| fclk_o | output | 1 | Master frame clock |
| qual_o | output | 1 | Master data qualifier strobe |
| sdata_o | output | 1 | Serial data |

## Verification
In slave mode the frame-clock edge and a bit-clock falling edge arrive in the same master-clock cycle at every channel boundary. The restart to slot 0 must win over the slot advance. The bench drives both external edges together at each half-frame boundary, with the qualifier both low and high, and judges the outcome from the data line: in justified mode it must show the MSB at once, in I2S mode a low slot followed by the MSB. In master mode, a sample pair is offered in the middle of a frame. The bench checks that the frame in progress is unchanged and that the new pair appears from the next left half.

// File: rtl/stser_pkg.sv
package stser_pkg;

  // mode_i[1] -> i2s, mode_i[0] -> master
  typedef struct packed {
    logic i2s;
    logic master;
  } ser_mode_t;

  // frame clock level that marks the left half
  function automatic logic left_level(input ser_mode_t m);
    return !m.i2s;
  endfunction

  // slot that carries the MSB
  function automatic logic msb_slot(input ser_mode_t m);
    return m.i2s | m.master;
  endfunction

endpackage

// File: rtl/stser_clkgen.sv
module stser_clkgen #(
  parameter int FRAME_SLOTS = 64,
  localparam int FS_W = $clog2(FRAME_SLOTS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            rate_384_i,
  output logic            bclk_o,
  output logic [FS_W-1:0] slot_o,
  output logic            frame_wrap_o
);

  logic [2:0] div_q;
  logic [2:0] half;
  logic [2:0] last;
  logic       adv;

  assign half = rate_384_i ? 3'd3 : 3'd2;
  assign last = {half[1:0], 1'b0} - 3'd1;
  assign adv  = en_i && (div_q == half - 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      slot_o <= '0;
    end else if (!en_i) begin
      div_q  <= '0;
      slot_o <= '0;
    end else begin
      div_q <= (div_q == last) ? 3'd0 : div_q + 3'd1;
      if (adv) slot_o <= slot_o + 1'b1;
    end
  end

  assign bclk_o       = en_i && (div_q < half);
  assign frame_wrap_o = adv && (slot_o == FS_W'(FRAME_SLOTS - 1));

  assert_bclk_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $rose(bclk_o) |=> bclk_o);
  assert_bclk_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $fell(bclk_o) |=> !bclk_o);
  assert_slot_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !$stable(slot_o) |-> $fell(bclk_o));

endmodule

// File: rtl/stser_slave_track.sv
module stser_slave_track #(
  parameter int CHAN_SLOTS  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W = $clog2(CHAN_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             i2s_i,
  input  logic             left_lvl_i,
  input  logic             ext_bclk_i,
  input  logic             ext_fclk_i,
  input  logic             ext_qual_i,
  output logic [POS_W-1:0] pos_o,
  output logic             chan_o,
  output logic             left_start_o
);

  localparam logic [POS_W-1:0] POS_MAX = POS_W'(CHAN_SLOTS - 1);

  logic [SYNC_STAGES-1:0] sb_q, sf_q, sq_q;
  logic b_s, f_s, q_s, b_prev, f_prev;
  logic bfall, fedge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb_q   <= '0;
      sf_q   <= '0;
      sq_q   <= '0;
      b_prev <= 1'b0;
      f_prev <= 1'b0;
    end else begin
      sb_q   <= {sb_q[SYNC_STAGES-2:0], ext_bclk_i};
      sf_q   <= {sf_q[SYNC_STAGES-2:0], ext_fclk_i};
      sq_q   <= {sq_q[SYNC_STAGES-2:0], ext_qual_i};
      b_prev <= b_s;
      f_prev <= f_s;
    end
  end

  assign b_s   = sb_q[SYNC_STAGES-1];
  assign f_s   = sf_q[SYNC_STAGES-1];
  assign q_s   = sq_q[SYNC_STAGES-1];
  assign bfall = b_prev && !b_s;
  assign fedge = f_prev != f_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      chan_o <= 1'b0;
    end else if (fedge) begin
      pos_o  <= '0;
      chan_o <= (f_s != left_lvl_i);
    end else if (bfall && (i2s_i || q_s) && pos_o != POS_MAX) begin
      pos_o <= pos_o + 1'b1;
    end
  end

  assign left_start_o = fedge && (f_s == left_lvl_i);

  assert_frame_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fedge |=> pos_o == '0);
  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfall && !fedge && !i2s_i && !q_s |=> $stable(pos_o));
  assert_qual_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2s_i && bfall && !fedge && pos_o != POS_MAX |=> pos_o == $past(pos_o) + 1'b1);

endmodule

// File: rtl/stser_sample_buf.sv
module stser_sample_buf #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                load_i,
  output logic [SAMPLE_W-1:0] shadow_l_o,
  output logic [SAMPLE_W-1:0] shadow_r_o
);

  logic                pend_vld;
  logic [SAMPLE_W-1:0] pend_l, pend_r;
  logic                accept;

  assign ready_o = !pend_vld;
  assign accept  = valid_i && !pend_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld   <= 1'b0;
      pend_l     <= '0;
      pend_r     <= '0;
      shadow_l_o <= '0;
      shadow_r_o <= '0;
    end else begin
      if (load_i && pend_vld) begin
        shadow_l_o <= pend_l;
        shadow_r_o <= pend_r;
        pend_vld   <= 1'b0;
      end
      if (accept) begin
        pend_l   <= left_i;
        pend_r   <= right_i;
        pend_vld <= 1'b1;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld && !load_i |=> pend_vld && $stable(pend_l) && $stable(pend_r));
  assert_shadow_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shadow_l_o) && $stable(shadow_r_o));

endmodule

// File: rtl/stser_bit_sel.sv
module stser_bit_sel #(
  parameter int SAMPLE_W = 20,
  parameter int POS_W    = 5
) (
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                first_i,
  output logic                bit_o
);

  logic [POS_W:0] rel;
  logic           in_word;

  assign rel     = {1'b0, pos_i} - {{POS_W{1'b0}}, first_i};
  assign in_word = ({1'b0, pos_i} >= {{POS_W{1'b0}}, first_i}) && (rel < (POS_W+1)'(SAMPLE_W));

  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < SAMPLE_W; k++) begin
      if (in_word && rel == (POS_W+1)'(SAMPLE_W - 1 - k)) bit_o = word_i[k];
    end
  end

endmodule

// File: rtl/stereo_out_serializer.sv
module stereo_out_serializer
  import stser_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int CHAN_SLOTS  = 32,
  parameter int QUAL_SLOTS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                rate_384_i,
  input  logic                smp_valid_i,
  output logic                smp_ready_o,
  input  logic [SAMPLE_W-1:0] smp_left_i,
  input  logic [SAMPLE_W-1:0] smp_right_i,
  input  logic                ext_bclk_i,
  input  logic                ext_fclk_i,
  input  logic                ext_qual_i,
  output logic                bclk_o,
  output logic                fclk_o,
  output logic                qual_o,
  output logic                sdata_o
);

  localparam int POS_W       = $clog2(CHAN_SLOTS);
  localparam int FRAME_SLOTS = 2 * CHAN_SLOTS;
  localparam int FS_W        = $clog2(FRAME_SLOTS);

  ser_mode_t m;
  logic      left_lvl;
  assign m        = ser_mode_t'(mode_i);
  assign left_lvl = left_level(m);

  logic [FS_W-1:0]  slot;
  logic             wrap;
  logic [POS_W-1:0] sl_pos, pos;
  logic             sl_chan, sl_left_start, chan, load;
  logic [SAMPLE_W-1:0] sh_l, sh_r, word;

  stser_clkgen #(.FRAME_SLOTS(FRAME_SLOTS)) u_clkgen (
    .clk_i, .rst_ni, .en_i(m.master), .rate_384_i,
    .bclk_o, .slot_o(slot), .frame_wrap_o(wrap)
  );

  stser_slave_track #(.CHAN_SLOTS(CHAN_SLOTS), .SYNC_STAGES(SYNC_STAGES)) u_track (
    .clk_i, .rst_ni, .i2s_i(m.i2s), .left_lvl_i(left_lvl),
    .ext_bclk_i, .ext_fclk_i, .ext_qual_i,
    .pos_o(sl_pos), .chan_o(sl_chan), .left_start_o(sl_left_start)
  );

  assign pos  = m.master ? slot[POS_W-1:0] : sl_pos;
  assign chan = m.master ? slot[POS_W]     : sl_chan;
  assign load = m.master ? wrap            : sl_left_start;

  stser_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .ready_o(smp_ready_o),
    .left_i(smp_left_i), .right_i(smp_right_i), .load_i(load),
    .shadow_l_o(sh_l), .shadow_r_o(sh_r)
  );

  assign word = chan ? sh_r : sh_l;

  stser_bit_sel #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_sel (
    .word_i(word), .pos_i(pos), .first_i(msb_slot(m)), .bit_o(sdata_o)
  );

  assign fclk_o = m.master && (chan ? !left_lvl : left_lvl);
  assign qual_o = m.master && (pos >= POS_W'(1)) && (pos <= POS_W'(QUAL_SLOTS));

  assert_qual_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m.master && $rose(qual_o) |-> $stable(fclk_o));
  assert_data_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m.master && !$stable(sdata_o) |-> $fell(bclk_o));

endmodule

// File: tb/stereo_out_serializer_test.sv
`timescale 1ns/1ps
module stereo_out_serializer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rate = 1'b0;
  logic vld = 1'b0;
  logic rdy;
  logic [19:0] dl = '0, dr = '0;
  logic eb = 1'b0, ef = 1'b0, eq = 1'b1;
  logic bclk, fclk, qual, sdata;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stereo_out_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .rate_384_i(rate),
    .smp_valid_i(vld), .smp_ready_o(rdy), .smp_left_i(dl), .smp_right_i(dr),
    .ext_bclk_i(eb), .ext_fclk_i(ef), .ext_qual_i(eq),
    .bclk_o(bclk), .fclk_o(fclk), .qual_o(qual), .sdata_o(sdata)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [19:0] w, input int pos, input int first);
    int rel;
    rel = pos - first;
    if (pos >= first && rel < 20) return w[19-rel];
    return 1'b0;
  endfunction

  task automatic do_reset(input logic [1:0] md, input logic r, input logic fidle);
    @(negedge clk);
    rst_n = 1'b0; mode = md; rate = r; vld = 1'b0;
    eb = 1'b0; ef = fidle; eq = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [19:0] l, input logic [19:0] r, input string req);
    chk(req, "ready before push", rdy, 1);
    dl = l; dr = r; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk(req, "ready after accept", rdy, 0);
  endtask

  task automatic wait_rise();
    logic p;
    p = bclk;
    forever begin
      @(negedge clk);
      if (bclk && !p) break;
      p = bclk;
    end
  endtask

  // R10 and R1: reset state in slave mode
  task automatic t_reset();
    do_reset(2'b00, 1'b0, 1'b0);
    chk("R10", "ready", rdy, 1);
    chk("R10", "sdata", sdata, 0);
    chk("R1", "slave bclk_o", bclk, 0);
    chk("R1", "slave fclk_o", fclk, 0);
    chk("R1", "slave qual_o", qual, 0);
  endtask

  // R5: bit clock period and high time
  task automatic t_rate(input logic r);
    int hi, tot;
    logic p;
    wait_rise();
    p = 1'b1; hi = 0; tot = 0;
    forever begin
      if (bclk) hi++;
      tot++;
      @(negedge clk);
      if (bclk && !p) break;
      p = bclk;
    end
    chk("R5", "bclk period", tot, r ? 6 : 4);
    chk("R5", "bclk high", hi, r ? 3 : 2);
  endtask

  // R2 R3 R4 R6 R9: capture one master frame from the start of a left half
  task automatic cap_frame(input logic [19:0] el, input logic [19:0] er, input logic lvl,
                           input int push_at, input logic [19:0] pl, input logic [19:0] pr);
    logic p;
    p = fclk;
    forever begin
      @(negedge clk);
      if (fclk == lvl && p != lvl) break;
      p = fclk;
    end
    for (int k = 0; k < 64; k++) begin
      if (k == push_at) push(pl, pr, "R9");
      wait_rise();
      chk("R3", $sformatf("data slot %0d", k), sdata,
          exp_bit(k < 32 ? el : er, k % 32, 1));
      chk("R2", $sformatf("fclk slot %0d", k), fclk, k < 32 ? lvl : !lvl);
      chk("R6", $sformatf("qual slot %0d", k), qual, ((k % 32) >= 1 && (k % 32) <= 16) ? 1 : 0);
    end
  endtask

  task automatic t_master(input logic [1:0] md, input logic r);
    logic lvl;
    lvl = !md[1];
    do_reset(md, r, 1'b0);
    t_rate(r);
    push(20'hA5C3E, 20'h81234, "R9");
    cap_frame(20'hA5C3E, 20'h81234, lvl, 10, 20'h7FFFF, 20'h80001); // R9 mid-frame push
    cap_frame(20'h7FFFF, 20'h80001, lvl, -1, '0, '0);                // R4 new pair
    chk("R9", "ready after load", rdy, 1);
    cap_frame(20'h7FFFF, 20'h80001, lvl, -1, '0, '0);                // R9 repeat
  endtask

  // R7 R8 R3 R4 R2: slave modes; frame edge coincides with a bit clock fall
  task automatic t_slave(input logic [1:0] md);
    logic lvl, i2s;
    int ep, first;
    logic [19:0] w;
    i2s = md[1]; lvl = !md[1]; first = i2s ? 1 : 0;
    do_reset(md, 1'b0, !lvl);
    eq = 1'b1;
    repeat (8) @(negedge clk);
    push(20'hC0F35, 20'h3A5A1, "R9");
    ep = 0;
    for (int c = 0; c < 2; c++) begin
      w = (c == 0) ? 20'hC0F35 : 20'h3A5A1;
      for (int i = 0; i < 32; i++) begin
        eb = 1'b1;
        if (i2s) eq = 1'b0;
        else eq = (c == 0 && i >= 4 && i <= 6) ? 1'b0 : 1'b1;
        repeat (8) @(negedge clk);
        eb = 1'b0;
        if (i == 0) ef = (c == 0) ? lvl : !lvl;
        repeat (8) @(negedge clk);
        if (i == 0) ep = 0;
        else if ((i2s || eq) && ep < 31) ep++;
        chk(i2s ? "R8" : "R7", $sformatf("ch%0d step %0d", c, i), sdata, exp_bit(w, ep, first));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_master(2'b01, 1'b0);
    t_master(2'b11, 1'b1);
    t_slave(2'b00);
    t_slave(2'b10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule